// File: doc/BRIEF.md
# Narrow/Wide Port Width Converter

This block sits on both data ports of a queue whose storage is always 18 bits wide. Each port runs either 9 or 18 bits wide. On the write side it packs two consecutive 9-bit words into one 18-bit storage word, or it forwards each write as one storage word. On the read side it splits one 18-bit storage word into two 9-bit reads, or it forwards each storage word as one read. The queue's pointers and flags lie outside the block. The block sees storage through a push strobe on the write side. On the read side it sees a show-ahead head word with an "available" input and a pop request.

Three configuration pins pick the write width, the read width and the byte order. They are sampled on every clock edge while master reset is low. After that they are held until the next master reset. The byte order decides which half of a wide word belongs to the earlier narrow word. A partial reset drops any half-built wide word on the write side and any half-consumed wide word on the read side. It keeps the latched configuration.

Top module: `bus_width_conv`

## Requirements
- R1: The write-width select (`cfg_in_wide`: 1 = 18 bits), the read-width select (`cfg_out_wide`: 1 = 18 bits) and the byte-order select (`cfg_big_endian`) are captured while `mrst_n` is low. Changes on these pins after `mrst_n` rises have no effect on the data path.
- R2: In 9-to-9 mode, every accepted write creates one storage word. Reads return the words in write order in `rd_data[8:0]`.
- R3: In 18-to-18 mode, every write is stored and read back unchanged, in order.
- R4: In 9-to-18 mode, two writes form one storage word. With big-endian order the earlier word goes to bits 17:9; with little-endian order it goes to bits 8:0. The first write of a pair produces no push. The second write produces one push.
- R5: In 18-to-9 mode, each storage word gives two reads. With big-endian order bits 17:9 come first; with little-endian order bits 8:0 come first. `st_pop` is asserted only on the read that returns the second half.
- R6: When the write port is 9 bits wide, `wr_data[17:9]` is ignored. When the read port is 9 bits wide, `rd_data[17:9]` reads as zero.
- R7: `st_push` and `st_wdata` appear one `wclk` cycle after the write that completes a storage word. A read is accepted only while `st_avail` is high, and `rd_data` with a one-cycle `rd_valid` pulse follows one `rclk` cycle later. A read request while `st_avail` is low produces no pop and no `rd_valid`.
- R8: A partial reset (`prst_n` low) discards a pending first narrow write. The next two writes form a fresh pair.
- R9: A partial reset clears a pending second half on the read side. The next read returns the first half of the head word.
- R10: During master reset, `st_push`, `st_pop` and `rd_valid` are low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous to each clock; latches configuration |
| prst_n | input | 1 | Partial reset, active low, synchronous; clears half-words only |
| cfg_in_wide | input | 1 | Write port width select, 1 = 18 bits |
| cfg_out_wide | input | 1 | Read port width select, 1 = 18 bits |
| cfg_big_endian | input | 1 | 1 = earlier narrow word in upper half |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write data; bits 8:0 only in narrow mode |
| st_push | output | 1 | Push one word into storage |
| st_wdata | output | 18 | Word pushed into storage |
| st_avail | input | 1 | Storage holds at least one word |
| st_rdata | input | 18 | Head word of storage (show-ahead) |
| st_pop | output | 1 | Remove head word from storage |
| rd_en | input | 1 | Read request |
| rd_data | output | 18 | Read data; bits 8:0 only in narrow mode |
| rd_valid | output | 1 | `rd_data` holds a new read result |

## Verification
A wrong half-word state on the write side shows up in two ways. First, `st_push` fires on the wrong write of a pair. Second, the halves of the next stored word are shifted by one narrow word, which the read returning that word exposes. A wrong half state on the read side shows up on the very next read as the wrong half or a repeated half. It also shows up as `st_pop` firing one read early or late, which loses or duplicates a storage word on every later read. A configuration register that follows its pins after reset swaps halves or widths at the first transfer after the pins move. The partial reset cases are checked on the first transfer after release.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  typedef struct packed {
    logic in_wide;
    logic out_wide;
    logic big_end;
  } bwc_cfg_t;

  typedef enum logic {
    BWC_FIRST  = 1'b0,
    BWC_SECOND = 1'b1
  } bwc_half_e;

endpackage

// File: rtl/bwc_cfg_latch.sv
module bwc_cfg_latch
  import bwc_pkg::*;
(
  input  logic     clk,
  input  logic     mrst_n,
  input  bwc_cfg_t cfg_pins,
  output bwc_cfg_t cfg_q
);

  always_ff @(posedge clk) begin
    if (!mrst_n) cfg_q <= cfg_pins;
  end

  // R1: configuration frozen once master reset is released
  a_r1_cfg_held: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> $stable(cfg_q));

endmodule

// File: rtl/bwc_packer.sv
module bwc_packer
  import bwc_pkg::*;
#(
  parameter int NW = 9,
  localparam int WW = 2 * NW
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  bwc_cfg_t      cfg,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_data,
  output logic          st_push,
  output logic [WW-1:0] st_wdata
);

  function automatic logic [WW-1:0] join_pair(logic [NW-1:0] early,
                                               logic [NW-1:0] late,
                                               logic big);
    return big ? {early, late} : {late, early};
  endfunction

  function automatic logic [WW-1:0] widen(logic [NW-1:0] n);
    return {{NW{1'b0}}, n};
  endfunction

  logic          pack_mode;
  logic          wr_take;
  logic [NW-1:0] wr_low;
  bwc_half_e     half_q;
  logic [NW-1:0] hold_q;

  assign pack_mode = !cfg.in_wide && cfg.out_wide;
  assign wr_take   = wr_en && prst_n;
  assign wr_low    = wr_data[NW-1:0];

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) begin
      half_q   <= BWC_FIRST;
      hold_q   <= '0;
      st_push  <= 1'b0;
      st_wdata <= '0;
    end else begin
      st_push <= 1'b0;
      if (wr_take) begin
        if (pack_mode) begin
          if (half_q == BWC_FIRST) begin
            hold_q <= wr_low;
            half_q <= BWC_SECOND;
          end else begin
            st_push  <= 1'b1;
            st_wdata <= join_pair(hold_q, wr_low, cfg.big_end);
            half_q   <= BWC_FIRST;
          end
        end else begin
          st_push  <= 1'b1;
          st_wdata <= cfg.in_wide ? wr_data : widen(wr_low);
        end
      end
    end
  end

  // R4: first write of a pair never pushes
  a_r4_first_holds: assert property (@(posedge clk) disable iff (!mrst_n)
    (pack_mode && wr_take && half_q == BWC_FIRST) |=> !st_push);
  // R4: second write of a pair pushes
  a_r4_second_pushes: assert property (@(posedge clk) disable iff (!mrst_n)
    (pack_mode && wr_take && half_q == BWC_SECOND) |=> (st_push && half_q == BWC_FIRST));
  // R7: pass-through writes push one cycle later
  a_r7_pass_push: assert property (@(posedge clk) disable iff (!mrst_n)
    (!pack_mode && wr_take) |=> st_push);
  // R8: partial reset drops the half-built word
  a_r8_prst_clears: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> (half_q == BWC_FIRST && !st_push));

endmodule

// File: rtl/bwc_unpacker.sv
module bwc_unpacker
  import bwc_pkg::*;
#(
  parameter int NW = 9,
  localparam int WW = 2 * NW
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  bwc_cfg_t      cfg,
  input  logic          rd_en,
  input  logic          st_avail,
  input  logic [WW-1:0] st_rdata,
  output logic          st_pop,
  output logic [WW-1:0] rd_data,
  output logic          rd_valid
);

  function automatic logic [NW-1:0] pick_half(logic [WW-1:0] w,
                                              logic second,
                                              logic big);
    return (big != second) ? w[WW-1:NW] : w[NW-1:0];
  endfunction

  function automatic logic [WW-1:0] widen(logic [NW-1:0] n);
    return {{NW{1'b0}}, n};
  endfunction

  logic          split_mode;
  logic          rd_fire;
  bwc_half_e     half_q;
  logic [WW-1:0] next_data;

  assign split_mode = cfg.in_wide && !cfg.out_wide;
  assign rd_fire    = rd_en && st_avail && prst_n && mrst_n;
  assign st_pop     = rd_fire && (!split_mode || half_q == BWC_SECOND);

  always_comb begin
    if (split_mode)
      next_data = widen(pick_half(st_rdata, half_q == BWC_SECOND, cfg.big_end));
    else if (!cfg.out_wide)
      next_data = widen(st_rdata[NW-1:0]);
    else
      next_data = st_rdata;
  end

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) begin
      half_q   <= BWC_FIRST;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) begin
        rd_data <= next_data;
        if (split_mode)
          half_q <= (half_q == BWC_FIRST) ? BWC_SECOND : BWC_FIRST;
      end
    end
  end

  // R5: each split read moves to the other half
  a_r5_half_advance: assert property (@(posedge clk) disable iff (!mrst_n)
    (split_mode && rd_fire) |=> (half_q != $past(half_q)));
  // R7: accepted read yields valid data next cycle
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!mrst_n)
    rd_fire |=> rd_valid);
  // R7: no valid pulse without an accepted read
  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!mrst_n)
    !rd_fire |=> !rd_valid);
  // R7: never pop an empty store
  a_r7_pop_needs_data: assert property (@(posedge clk) disable iff (!mrst_n)
    st_pop |-> (st_avail && rd_en));
  // R6: narrow output upper bits are zero
  a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (!mrst_n)
    (rd_valid && !cfg.out_wide) |-> (rd_data[WW-1:NW] == '0));
  // R9: partial reset forgets a pending half
  a_r9_prst_clears: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> (half_q == BWC_FIRST && !rd_valid));

endmodule

// File: rtl/bus_width_conv.sv
module bus_width_conv
  import bwc_pkg::*;
#(
  parameter int NW = 9,
  localparam int WW = 2 * NW
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          cfg_in_wide,
  input  logic          cfg_out_wide,
  input  logic          cfg_big_endian,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_data,
  output logic          st_push,
  output logic [WW-1:0] st_wdata,
  input  logic          st_avail,
  input  logic [WW-1:0] st_rdata,
  output logic          st_pop,
  input  logic          rd_en,
  output logic [WW-1:0] rd_data,
  output logic          rd_valid
);

  bwc_cfg_t cfg_pins;
  bwc_cfg_t wcfg;
  bwc_cfg_t rcfg;

  assign cfg_pins = '{in_wide: cfg_in_wide, out_wide: cfg_out_wide, big_end: cfg_big_endian};

  bwc_cfg_latch u_wcfg (
    .clk      (wclk),
    .mrst_n   (mrst_n),
    .cfg_pins (cfg_pins),
    .cfg_q    (wcfg)
  );

  bwc_cfg_latch u_rcfg (
    .clk      (rclk),
    .mrst_n   (mrst_n),
    .cfg_pins (cfg_pins),
    .cfg_q    (rcfg)
  );

  bwc_packer #(.NW(NW)) u_pack (
    .clk      (wclk),
    .mrst_n   (mrst_n),
    .prst_n   (prst_n),
    .cfg      (wcfg),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .st_push  (st_push),
    .st_wdata (st_wdata)
  );

  bwc_unpacker #(.NW(NW)) u_unpack (
    .clk      (rclk),
    .mrst_n   (mrst_n),
    .prst_n   (prst_n),
    .cfg      (rcfg),
    .rd_en    (rd_en),
    .st_avail (st_avail),
    .st_rdata (st_rdata),
    .st_pop   (st_pop),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  // R10: outputs quiet while master reset is held
  a_r10_reset_quiet: assert property (@(posedge wclk)
    ($past(!mrst_n) && !mrst_n) |-> (!st_push && !rd_valid && rd_data == '0));

endmodule

// File: tb/bus_width_conv_test.sv
`timescale 1ns/1ps
module bus_width_conv_test;
  localparam int NW = 9;
  localparam int WW = 18;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic mrst_n = 1'b0, prst_n = 1'b1;
  logic cfg_in_wide = 1'b0, cfg_out_wide = 1'b0, cfg_big_endian = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [WW-1:0] wr_data = '0;
  logic st_push, st_pop, rd_valid, st_avail;
  logic [WW-1:0] st_wdata, st_rdata, rd_data;

  bus_width_conv #(.NW(NW)) uut (
    .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .cfg_in_wide(cfg_in_wide), .cfg_out_wide(cfg_out_wide), .cfg_big_endian(cfg_big_endian),
    .wr_en(wr_en), .wr_data(wr_data), .st_push(st_push), .st_wdata(st_wdata),
    .st_avail(st_avail), .st_rdata(st_rdata), .st_pop(st_pop),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // storage stand-in
  logic [WW-1:0] mem [0:255];
  logic [7:0] wp, rp;
  assign st_avail = (wp != rp);
  assign st_rdata = mem[rp];
  always @(posedge clk) begin
    if (!mrst_n || !prst_n) begin
      wp <= '0; rp <= '0;
    end else begin
      if (st_push) begin mem[wp] <= st_wdata; wp <= wp + 8'd1; end
      if (st_pop) rp <= rp + 8'd1;
    end
  end

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  string cur_tag = "R2";
  bit m_in_w, m_out_w, m_be, rd_half, mon_en;
  logic [NW-1:0] units[$];
  logic [WW-1:0] expq[$];

  task automatic check(bit ok, string req, logic [WW-1:0] act, logic [WW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [WW-1:0] ref_join(logic [NW-1:0] a, logic [NW-1:0] b, bit be);
    logic [WW-1:0] r;
    if (be) r = {a, b}; else r = {b, a};
    return r;
  endfunction

  task automatic model_write(logic [WW-1:0] d);
    if (m_in_w) begin
      units.push_back(m_be ? d[17:9] : d[8:0]);
      units.push_back(m_be ? d[8:0] : d[17:9]);
    end else units.push_back(d[8:0]);
    if (m_out_w) begin
      while (units.size() >= 2) begin
        logic [NW-1:0] a, b;
        a = units.pop_front(); b = units.pop_front();
        expq.push_back(ref_join(a, b, m_be));
      end
    end else begin
      while (units.size() > 0) expq.push_back({{NW{1'b0}}, units.pop_front()});
    end
  endtask

  always @(negedge clk) begin
    if (mon_en && rd_valid === 1'b1) begin
      if (expq.size() == 0) check(1'b0, cur_tag, rd_data, '0);
      else begin
        logic [WW-1:0] e;
        e = expq.pop_front();
        check(rd_data === e, cur_tag, rd_data, e);
      end
      if (!m_out_w) check(rd_data[17:9] === '0, "R6", rd_data, {9'b0, rd_data[8:0]});
    end
  end

  task automatic do_write(logic [WW-1:0] d);
    bit exp_push;
    exp_push = !(!m_in_w && m_out_w && units.size() == 0);
    @(posedge clk); #1; wr_en = 1'b1; wr_data = d;
    model_write(d);
    @(posedge clk); #1; wr_en = 1'b0;
    @(negedge clk);
    check(st_push === exp_push, (!m_in_w && m_out_w) ? "R4" : "R7",
          {17'b0, st_push}, {17'b0, exp_push});
  endtask

  task automatic do_read();
    bit split, exp_pop;
    split = m_in_w && !m_out_w;
    wait (st_avail === 1'b1);
    @(posedge clk); #1; rd_en = 1'b1;
    exp_pop = !split || rd_half;
    @(negedge clk);
    check(st_pop === exp_pop, "R5", {17'b0, st_pop}, {17'b0, exp_pop});
    if (split) rd_half = !rd_half;
    @(posedge clk); #1; rd_en = 1'b0;
  endtask

  task automatic do_prst();
    @(posedge clk); #1; prst_n = 1'b0;
    @(posedge clk); #1; prst_n = 1'b1;
    units.delete(); expq.delete(); rd_half = 0;
  endtask

  task automatic do_mrst(bit iw, bit ow, bit be);
    @(posedge clk); #1;
    mrst_n = 1'b0; cfg_in_wide = iw; cfg_out_wide = ow; cfg_big_endian = be;
    m_in_w = iw; m_out_w = ow; m_be = be;
    units.delete(); expq.delete(); rd_half = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(st_push === 1'b0 && rd_valid === 1'b0 && st_pop === 1'b0, "R10",
          {15'b0, st_push, rd_valid, st_pop}, '0);
    check(rd_data === '0, "R10", rd_data, '0);
    @(posedge clk); #1; mrst_n = 1'b1;
    // R1: pins wander after reset; latched settings must hold
    @(posedge clk); #1;
    cfg_in_wide = 1'($urandom); cfg_out_wide = 1'($urandom); cfg_big_endian = 1'($urandom);
  endtask

  task automatic run_mode(bit iw, bit ow, bit be);
    int nread;
    do_mrst(iw, ow, be);
    if (!iw && !ow) cur_tag = "R2";
    else if (iw && ow) cur_tag = "R3";
    else if (!iw) cur_tag = "R4";
    else cur_tag = "R5";
    for (int i = 0; i < 12; i++) begin
      do_write(18'($urandom));
      repeat ($urandom % 3) @(posedge clk);
    end
    nread = expq.size();
    for (int i = 0; i < nread; i++) begin
      do_read();
      repeat ($urandom % 2) @(posedge clk);
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(expq.size() == 0, "R1", WW'(expq.size()), '0);
    check(st_avail === 1'b0, cur_tag, {17'b0, st_avail}, '0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    mon_en = 1'b1;
    for (int m = 0; m < 8; m++) run_mode(m[2], m[1], m[0]);

    // R7: read request with empty storage is ignored
    @(posedge clk); #1; rd_en = 1'b1;
    @(negedge clk);
    check(st_pop === 1'b0, "R7", {17'b0, st_pop}, '0);
    @(posedge clk); #1; rd_en = 1'b0;
    @(negedge clk);
    check(rd_valid === 1'b0, "R7", {17'b0, rd_valid}, '0);

    // R8: half-built pair dropped by partial reset
    do_mrst(1'b0, 1'b1, 1'b1);
    cur_tag = "R8";
    do_write(18'h0_01AB);
    do_prst();
    do_write(18'h3_FE11);
    do_write(18'h0_0022);
    check(expq.size() == 1 && expq[0] == {9'h011, 9'h022}, "R8", expq[0], {9'h011, 9'h022});
    do_read();
    repeat (2) @(posedge clk);

    // R9: pending second half dropped by partial reset
    do_mrst(1'b1, 1'b0, 1'b0);
    cur_tag = "R9";
    do_write({9'h155, 9'h0AA});
    do_read();
    repeat (2) @(posedge clk);
    do_prst();
    do_write({9'h133, 9'h044});
    do_read();
    do_read();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(expq.size() == 0, "R9", WW'(expq.size()), '0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule